// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block keeps the coherence directory state for a set of memory blocks. Each block has a few sharer slots instead of one presence bit per node. A slot is a node ID of log2(NODES) bits with its own valid bit. Each entry also carries an overflow flag and a dirty flag. A request names a block index, an operation and a node. It arrives on a valid/ready channel and is taken in one cycle.

Adds and removes only edit the entry. A set-owner request or an invalidate-all request snapshots the entry and rewrites it in the same cycle. The block then walks the snapshot and sends the node IDs that must be invalidated on a second valid/ready channel, one target per handshake. Normally the targets are the recorded pointers, sent in slot order. When a block has gained more sharers than it has slots, the entry is in overflow mode and the walk visits every node ID in ascending order instead.

Top module: `sharer_ptr_dir`

## Requirements
- R1: After reset `req_ready` is 1, `inv_valid` is 0, and every entry is empty, so an invalidate-all request on any block sends no target.
- R2: An add (op code 0) of a node that is not recorded writes it into the lowest-numbered free slot. The walks of set-owner and invalidate-all send recorded pointers in ascending slot order.
- R3: An add of a node that is already recorded leaves the entry unchanged.
- R4: A remove (op code 1) clears the slot that holds the node. In overflow mode a remove has no effect.
- R5: An add of a new node when all PTRS slots hold other nodes sets the overflow flag. Further adds to an entry in overflow have no effect.
- R6: A set-owner (op code 2) sends one target for each recorded sharer other than the writer. Afterwards the entry holds only the writer, in slot 0, with the dirty flag set.
- R7: With the overflow flag set, a walk sends every node ID from 0 to NODES-1 in ascending order. Set-owner skips the writer; invalidate-all skips nobody.
- R8: An invalidate-all (op code 3) sends one target per recorded sharer. Afterwards the entry has no sharers, no overflow flag and no dirty flag.
- R9: `inv_recall` is 1 on every target of a walk whose entry was dirty when the request was taken. An add of a new sharer or a remove of a recorded one clears the dirty flag.
- R10: `req_ready` is 0 while a walk is in progress. While `inv_valid` is high and `inv_ready` is low, `inv_valid`, `inv_node` and `inv_recall` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 2 | 0 add, 1 remove, 2 set-owner, 3 invalidate-all |
| req_idx | input | log2(BLOCKS) | Block index |
| req_node | input | log2(NODES) | Sharer, writer or requester node ID |
| inv_valid | output | 1 | Invalidation target present |
| inv_ready | input | 1 | Target consumed this cycle if valid |
| inv_node | output | log2(NODES) | Node to invalidate |
| inv_recall | output | 1 | Entry was dirty: the target holds the owned copy |

## Verification
The entry is written on the clock edge that accepts the request. A request presented in the very next cycle therefore already sees the new entry. The first invalidation target of a walk appears one cycle after the accepting edge. Each later target appears one cycle after the previous handshake, or as soon as the walk reaches the next valid slot. `req_ready` rises again in the cycle after the walk passes its last position. The bench drives inputs and samples outputs on the falling edge. It records a target only when valid and ready are both high at that sample, which places the handshake on the next rising edge. It ends the collection only when `req_ready` is back, so no check depends on a guessed latency. A stalled run holds `inv_ready` low for two samples per target to exercise the hold rule.

// File: rtl/sharer_ptr_dir.sv
module sharer_ptr_dir #(
  parameter int NODES  = 16,
  parameter int PTRS   = 5,
  parameter int BLOCKS = 8,
  localparam int ID_W  = $clog2(NODES),
  localparam int IDX_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [ID_W-1:0]  req_node,
  output logic             inv_valid,
  input  logic             inv_ready,
  output logic [ID_W-1:0]  inv_node,
  output logic             inv_recall
);
  localparam int SL_W  = (PTRS > 1) ? $clog2(PTRS) : 1;
  localparam int SPAN  = (NODES > PTRS) ? NODES : PTRS;
  localparam int CUR_W = $clog2(SPAN) + 1;

  typedef enum logic [1:0] {OP_ADD, OP_REM, OP_OWN, OP_INV} op_e;

  logic [PTRS-1:0] ent_v  [BLOCKS];
  logic [ID_W-1:0] ent_id [BLOCKS][PTRS];
  logic [BLOCKS-1:0] ent_ovf, ent_dirty;

  logic            busy, w_ovf, w_skip, w_dirty;
  logic [ID_W-1:0] w_req;
  logic [PTRS-1:0] w_v;
  logic [ID_W-1:0] w_id [PTRS];
  logic [CUR_W-1:0] cur;

  logic [PTRS-1:0] e_v, hit;
  logic            free_found;
  logic [SL_W-1:0] free_slot;
  logic            accept;

  assign e_v       = ent_v[req_idx];
  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  for (genvar i = 0; i < PTRS; i++) begin : g_hit
    assign hit[i] = e_v[i] && (ent_id[req_idx][i] == req_node);
  end

  always_comb begin
    free_found = 1'b0;
    free_slot  = '0;
    for (int i = PTRS - 1; i >= 0; i--) begin
      if (!e_v[i]) begin
        free_found = 1'b1;
        free_slot  = SL_W'(i);
      end
    end
  end

  logic [ID_W-1:0] slot_id;
  logic            slot_ok, emit, step;
  logic [CUR_W-1:0] last;

  always_comb begin
    slot_id = '0;
    slot_ok = 1'b0;
    for (int i = 0; i < PTRS; i++) begin
      if (cur == CUR_W'(i)) begin
        slot_id = w_id[i];
        slot_ok = w_v[i];
      end
    end
  end

  assign inv_node   = w_ovf ? cur[ID_W-1:0] : slot_id;
  assign emit       = busy && (w_ovf || slot_ok) && !(w_skip && inv_node == w_req);
  assign inv_valid  = emit;
  assign inv_recall = busy && w_dirty;
  assign last       = w_ovf ? CUR_W'(NODES - 1) : CUR_W'(PTRS - 1);
  assign step       = busy && (!emit || inv_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < BLOCKS; b++) begin
        ent_v[b] <= '0;
        for (int p = 0; p < PTRS; p++) ent_id[b][p] <= '0;
      end
      for (int p = 0; p < PTRS; p++) w_id[p] <= '0;
      ent_ovf   <= '0;
      ent_dirty <= '0;
      busy      <= 1'b0;
      w_ovf     <= 1'b0;
      w_skip    <= 1'b0;
      w_dirty   <= 1'b0;
      w_req     <= '0;
      w_v       <= '0;
      cur       <= '0;
    end else begin
      if (step) begin
        if (cur == last) busy <= 1'b0;
        else             cur  <= cur + 1'b1;
      end
      if (accept) begin
        case (op_e'(req_op))
          OP_ADD: begin
            if (!ent_ovf[req_idx] && hit == '0) begin
              if (free_found) begin
                ent_v[req_idx][free_slot]  <= 1'b1;
                ent_id[req_idx][free_slot] <= req_node;
              end else begin
                ent_ovf[req_idx] <= 1'b1;
                ent_v[req_idx]   <= '0;
              end
              ent_dirty[req_idx] <= 1'b0;
            end
          end
          OP_REM: begin
            if (!ent_ovf[req_idx] && hit != '0) begin
              ent_v[req_idx]     <= e_v & ~hit;
              ent_dirty[req_idx] <= 1'b0;
            end
          end
          default: begin
            busy    <= 1'b1;
            cur     <= '0;
            w_ovf   <= ent_ovf[req_idx];
            w_dirty <= ent_dirty[req_idx];
            w_skip  <= (req_op == OP_OWN);
            w_req   <= req_node;
            w_v     <= e_v;
            w_id    <= ent_id[req_idx];
            ent_ovf[req_idx] <= 1'b0;
            if (req_op == OP_OWN) begin
              ent_v[req_idx]     <= PTRS'(1);
              ent_id[req_idx][0] <= req_node;
              ent_dirty[req_idx] <= 1'b1;
            end else begin
              ent_v[req_idx]     <= '0;
              ent_dirty[req_idx] <= 1'b0;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sharer_ptr_dir_chk.sv
module sharer_ptr_dir_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            inv_valid,
  input logic            inv_ready,
  input logic [ID_W-1:0] inv_node,
  input logic            inv_recall,
  input logic            w_ovf,
  input logic            w_skip,
  input logic [ID_W-1:0] w_req
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (req_ready && !inv_valid));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_ready) |=> (inv_valid && $stable(inv_node) && $stable(inv_recall)));

  // R7
  ovf_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_ready && w_ovf) |=> (!inv_valid || inv_node > $past(inv_node)));

  // R6
  writer_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && w_skip) |-> (inv_node != w_req));
endmodule

bind sharer_ptr_dir sharer_ptr_dir_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .inv_valid(inv_valid),
  .inv_ready(inv_ready), .inv_node(inv_node), .inv_recall(inv_recall),
  .w_ovf(w_ovf), .w_skip(w_skip), .w_req(w_req)
);

// File: tb/sharer_ptr_dir_tb.sv
module sharer_ptr_dir_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req_valid = 0;
  logic       req_ready;
  logic [1:0] req_op = 0;
  logic [2:0] req_idx = 0;
  logic [3:0] req_node = 0;
  logic       inv_valid;
  logic       inv_ready = 1;
  logic [3:0] inv_node;
  logic       inv_recall;

  always #4 clk = ~clk;

  sharer_ptr_dir u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_idx(req_idx), .req_node(req_node),
    .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
    .inv_recall(inv_recall)
  );

  int nvec = 0, nbad = 0;
  int got [0:31];
  int got_n;
  bit rec;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int op, input int idx, input int node, input bit stall);
    int hold = 0;
    int prev = 0;
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_idx = 3'(idx); req_node = 4'(node);
    inv_ready = !stall;
    @(negedge clk);
    req_valid = 0;
    got_n = 0; rec = 0;
    while (!req_ready) begin
      if (stall) inv_ready = inv_valid && hold >= 2;
      if (inv_valid) begin
        if (inv_ready) begin
          got[got_n] = int'(inv_node); got_n++; rec |= inv_recall; hold = 0;
        end else begin
          if (hold > 0) chk(int'(inv_node) == prev, "R10 stall hold", int'(inv_node), prev);
          prev = int'(inv_node); hold++;
        end
      end
      @(negedge clk);
    end
    inv_ready = 1;
  endtask

  // {op2, idx3, node4, count5, first4, recall1, tag4}
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 3'd1, 4'd3,  5'd0, 4'd0, 1'b0, 4'd2},  // R2
    {2'd0, 3'd1, 4'd7,  5'd0, 4'd0, 1'b0, 4'd2},  // R2
    {2'd0, 3'd1, 4'd3,  5'd0, 4'd0, 1'b0, 4'd3},  // R3 duplicate
    {2'd0, 3'd1, 4'd12, 5'd0, 4'd0, 1'b0, 4'd2},  // R2
    {2'd2, 3'd1, 4'd7,  5'd2, 4'd3, 1'b0, 4'd6},  // R6 targets 3,12
    {2'd0, 3'd1, 4'd5,  5'd0, 4'd0, 1'b0, 4'd9},  // R9 add clears dirty
    {2'd3, 3'd1, 4'd0,  5'd2, 4'd7, 1'b0, 4'd8},  // R8 targets 7,5
    {2'd0, 3'd2, 4'd9,  5'd0, 4'd0, 1'b0, 4'd2},  // R2
    {2'd2, 3'd2, 4'd9,  5'd0, 4'd0, 1'b0, 4'd6},  // R6 writer only
    {2'd2, 3'd2, 4'd4,  5'd1, 4'd9, 1'b1, 4'd9},  // R9 recall owner 9
    {2'd3, 3'd2, 4'd1,  5'd1, 4'd4, 1'b1, 4'd9},  // R9 recall owner 4
    {2'd3, 3'd2, 4'd1,  5'd0, 4'd0, 1'b0, 4'd8},  // R8 cleared
    {2'd0, 3'd3, 4'd4,  5'd0, 4'd0, 1'b0, 4'd2},  // R2
    {2'd0, 3'd3, 4'd6,  5'd0, 4'd0, 1'b0, 4'd2},  // R2
    {2'd1, 3'd3, 4'd4,  5'd0, 4'd0, 1'b0, 4'd4},  // R4 remove
    {2'd3, 3'd3, 4'd0,  5'd1, 4'd6, 1'b0, 4'd4}   // R4 only 6 left
  };

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 req_ready", int'(req_ready), 1);
    chk(inv_valid == 0, "R1 inv_valid", int'(inv_valid), 0);
    run(3, 0, 0, 0);
    chk(got_n == 0, "R1 empty entry", got_n, 0);

    for (int v = 0; v < NV; v++) begin
      logic [22:0] e;
      e = VEC[v];
      run(int'(e[22:21]), int'(e[20:18]), int'(e[17:14]), 0);
      chk(got_n == int'(e[13:9]), $sformatf("R%0d vec %0d count", e[3:0], v), got_n, int'(e[13:9]));
      if (e[13:9] != 0) begin
        chk(got[0] == int'(e[8:5]), $sformatf("R%0d vec %0d first", e[3:0], v), got[0], int'(e[8:5]));
        chk(rec == e[4], $sformatf("R%0d vec %0d recall", e[3:0], v), int'(rec), int'(e[4]));
      end
    end

    // R2 lowest free slot reused, slot order, with stalls (R10)
    run(0, 6, 10, 0); run(0, 6, 11, 0); run(0, 6, 12, 0);
    run(1, 6, 10, 0); run(0, 6, 13, 0);
    run(3, 6, 0, 1);
    chk(got_n == 3, "R2 count", got_n, 3);
    chk(got[0] == 13 && got[1] == 11 && got[2] == 12, "R2 order", got[0], 13);

    // R5 overflow, then R7 set-owner broadcast skipping writer
    for (int n = 1; n <= 6; n++) run(0, 4, n, 0);
    run(0, 4, 9, 0);
    run(2, 4, 2, 0);
    chk(got_n == 15, "R5 R7 broadcast count", got_n, 15);
    for (int k = 0; k < 15; k++) begin
      int ex;
      ex = (k < 2) ? k : k + 1;
      chk(got[k] == ex, "R7 ascending skip writer", got[k], ex);
    end
    chk(rec == 0, "R7 recall", int'(rec), 0);
    run(3, 4, 0, 0);
    chk(got_n == 1 && got[0] == 2, "R6 owner in slot 0", got[0], 2);
    chk(rec == 1, "R6 dirty recall", int'(rec), 1);

    // R4 remove ignored in overflow, R8 broadcast then clear
    for (int n = 0; n <= 5; n++) run(0, 5, n, 0);
    run(1, 5, 3, 0);
    run(3, 5, 7, 1);
    chk(got_n == 16, "R4 R8 broadcast count", got_n, 16);
    for (int k = 0; k < 16; k++) chk(got[k] == k, "R7 ascending all", got[k], k);
    run(3, 5, 7, 0);
    chk(got_n == 0, "R8 overflow cleared", got_n, 0);

    finish_up();
  end
endmodule